// File: doc/BRIEF.md
# Presettable Gated Down Counter

This block is a single-stage preset down counter. Two count inputs, A and B, act as a count line and a gate line. A pairing select decides which input counts and on which edge. The present value (PV) counts down from a preset value that is captured when an external clear is accepted. When PV arrives at zero, two outputs assert together. The outputs either give a pulse of programmable length or stay on until the next accepted clear.

Every external input goes through a two-flop synchroniser and then an edge detector, so each count edge gives exactly one decrement. A clear takes effect only once it has stayed high for a programmable minimum number of cycles. Counting stays blocked for as long as the clear is high, and it resumes after the clear falls. A mode input picks what happens when a count edge arrives at zero: the value wraps to 999999, or it holds at zero. All pins are plain control and status levels; the block has no streaming interface and no back-pressure.

Top module: `preset_down_counter`

## Requirements
- R1: After `rst_n` is released, `pv_o` is 0 and both outputs are low.
- R2: With `pair_sel_i`=0, each rising edge on `cnt_a_i` lowers PV by one while `cnt_b_i` is low. While `cnt_b_i` is high, these edges have no effect.
- R3: With `pair_sel_i`=1, each falling edge on `cnt_b_i` lowers PV by one while `cnt_a_i` is high. While `cnt_a_i` is low, these edges have no effect.
- R4: An accepted clear loads PV with `preset_i` as sampled at that moment and drops both outputs. A preset above 999999 loads as 999999. Later changes of `preset_i` do not alter PV.
- R5: While the synchronised clear is high, count edges do not change PV. Counting resumes after the clear falls.
- R6: A clear is accepted only after it has been high for at least `clr_min_i` consecutive cycles, with 0 treated as 1. A shorter clear leaves PV and the outputs unchanged.
- R7: When a decrement takes PV from 1 to 0, `out1_o` and `out2_o` both go high on the same clock edge that makes PV zero.
- R8: With `wrap_en_i`=0, PV stays at 0 on further count edges.
- R9: With `wrap_en_i`=1, a count edge at PV=0 gives 999999 and counting continues. The outputs keep following the output mode.
- R10: With `latch_en_i`=0, the outputs stay high for exactly `pulse_len_i` cycles, with 0 treated as 1.
- R11: With `latch_en_i`=1, the outputs stay high until the next accepted clear, whatever the further count edges.
- R12: If a count edge and the start of a clear reach the counter in the same cycle, the clear wins and PV equals the preset afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_a_i | input | 1 | Count input A (counts in pairing 0, gates in pairing 1) |
| cnt_b_i | input | 1 | Count input B (gates in pairing 0, counts in pairing 1) |
| clr_i | input | 1 | External clear; reloads the preset and blocks counting while high |
| pair_sel_i | input | 1 | 0: A rising edge counts, B high blocks; 1: B falling edge counts, A low blocks |
| wrap_en_i | input | 1 | 1: wrap from 0 to 999999; 0: hold at 0 |
| latch_en_i | input | 1 | 1: outputs latch until clear; 0: timed pulse |
| preset_i | input | 20 | Setting value loaded on an accepted clear |
| clr_min_i | input | 8 | Minimum clear width in cycles |
| pulse_len_i | input | 16 | Output pulse length in cycles |
| pv_o | output | 20 | Present value |
| out1_o | output | 1 | Compare output 1 |
| out2_o | output | 1 | Compare output 2 |

## Verification
The bench goes after the following corner cases:
- **Gate input:** it toggles the gate input of each pairing. A design that used the wrong edge polarity, or ignored the gate, would count edges that must be blocked.
- **Clear filter:** it sends clears shorter than, and exactly equal to, the minimum width. An off-by-one filter would either reload on the short clear or miss the exact-width one.
- **Clear timing:** it lines up a count edge with the start of a clear, and counts during a long clear. A design that let counting slip past the clear would end with PV one below the preset.
- **Zero boundary:** it crosses zero in both past-zero modes and measures the pulse length cycle by cycle, including a length of zero. A wrong design would wrap while holding, or stick at zero while wrapping, or give a pulse one cycle long or short.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    PAIR_A_RISE = 1'b0,
    PAIR_B_FALL = 1'b1
  } pair_e;

  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam int IDX_CLR = 2;
  localparam int N_SYNC  = 3;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
        prev_q <= stab_q;
      end
    end

    assign lvl_o[g]  = stab_q;
    assign rise_o[g] = stab_q & ~prev_q;
    assign fall_o[g] = ~stab_q & prev_q;

    // R2: one input edge gives a single-cycle edge strobe
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/pdc_clr_filter.sv
module pdc_clr_filter #(
  parameter int CLR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_lvl_i,
  input  logic [CLR_W-1:0] min_i,
  output logic             accept_o
);
  localparam int RUN_W = CLR_W + 1;

  logic [CLR_W-1:0] run_q;
  logic             taken_q;
  logic [RUN_W-1:0] thresh;
  logic [RUN_W-1:0] run_next;

  assign thresh   = (min_i == '0) ? RUN_W'(1) : {1'b0, min_i};
  assign run_next = {1'b0, run_q} + RUN_W'(1);
  assign accept_o = clr_lvl_i && !taken_q && (run_next >= thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      taken_q <= 1'b0;
    end else if (!clr_lvl_i) begin
      run_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      if (run_q != '1) run_q <= run_q + CLR_W'(1);
      if (accept_o) taken_q <= 1'b1;
    end
  end

  // R6: a clear is taken at most once per high phase
  assert_one_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);
endmodule

// File: rtl/pdc_value.sv
module pdc_value #(
  parameter int PV_W      = 20,
  parameter int MAX_VALUE = 999999
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [PV_W-1:0] preset_i,
  input  logic            dec_i,
  input  logic            wrap_i,
  output logic [PV_W-1:0] pv_o,
  output logic            zero_hit_o
);
  localparam logic [PV_W-1:0] TOP = PV_W'(MAX_VALUE);

  logic [PV_W-1:0] pv_q;
  logic            at_zero;

  assign at_zero    = (pv_q == '0);
  assign zero_hit_o = dec_i && !load_i && (pv_q == PV_W'(1));
  assign pv_o       = pv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= '0;
    end else if (load_i) begin
      pv_q <= (preset_i > TOP) ? TOP : preset_i;
    end else if (dec_i) begin
      if (!at_zero)    pv_q <= pv_q - PV_W'(1);
      else if (wrap_i) pv_q <= TOP;
    end
  end

  assert_pv_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q <= TOP);
  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !wrap_i && !load_i) |=> (pv_q == '0));
  assert_load_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && preset_i <= TOP) |=> (pv_q == $past(preset_i)));
endmodule

// File: rtl/pdc_outputs.sv
module pdc_outputs #(
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic               clear_i,
  input  logic               latch_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               out_o
);
  logic [PULSE_W-1:0] tmr_q;
  logic               lat_q;
  logic [PULSE_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? PULSE_W'(1) : len_i;
  assign out_o   = latch_i ? lat_q : (tmr_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
      lat_q <= 1'b0;
    end else if (clear_i) begin
      tmr_q <= '0;
      lat_q <= 1'b0;
    end else if (hit_i) begin
      tmr_q <= len_eff;
      lat_q <= 1'b1;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - PULSE_W'(1);
    end
  end

  assert_hit_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !clear_i) |=> (lat_q && tmr_q != '0));
  assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clear_i) |=> lat_q);
  assert_pulse_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == PULSE_W'(1) && !hit_i && !clear_i) |=> (tmr_q == '0));
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
  parameter int PV_W      = 20,
  parameter int MAX_VALUE = 999999,
  parameter int CLR_W     = 8,
  parameter int PULSE_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_a_i,
  input  logic               cnt_b_i,
  input  logic               clr_i,
  input  logic               pair_sel_i,
  input  logic               wrap_en_i,
  input  logic               latch_en_i,
  input  logic [PV_W-1:0]    preset_i,
  input  logic [CLR_W-1:0]   clr_min_i,
  input  logic [PULSE_W-1:0] pulse_len_i,
  output logic [PV_W-1:0]    pv_o,
  output logic               out1_o,
  output logic               out2_o
);
  import pdc_pkg::*;

  logic [N_SYNC-1:0] raw, lvl, rise, fall;
  logic  accept, dec, hit, out_any;
  pair_e pair;

  assign raw[IDX_A]   = cnt_a_i;
  assign raw[IDX_B]   = cnt_b_i;
  assign raw[IDX_CLR] = clr_i;
  assign pair         = pair_e'(pair_sel_i);

  pdc_sync #(.N(N_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pdc_clr_filter #(.CLR_W(CLR_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .clr_lvl_i(lvl[IDX_CLR]),
    .min_i(clr_min_i), .accept_o(accept)
  );

  always_comb begin
    unique case (pair)
      PAIR_A_RISE: dec = rise[IDX_A] & ~lvl[IDX_B];
      PAIR_B_FALL: dec = fall[IDX_B] & lvl[IDX_A];
      default:     dec = 1'b0;
    endcase
    if (lvl[IDX_CLR]) dec = 1'b0;
  end

  pdc_value #(.PV_W(PV_W), .MAX_VALUE(MAX_VALUE)) u_value (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .preset_i(preset_i),
    .dec_i(dec), .wrap_i(wrap_en_i), .pv_o(pv_o), .zero_hit_o(hit)
  );

  pdc_outputs #(.PULSE_W(PULSE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .clear_i(accept),
    .latch_i(latch_en_i), .len_i(pulse_len_i), .out_o(out_any)
  );

  assign out1_o = out_any;
  assign out2_o = out_any;

  // R5, R12: no change of PV while the clear is high and not being taken
  assert_blocked_in_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[IDX_CLR] && !accept) |=> $stable(pv_o));
  assert_clear_drops_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && latch_en_i) |=> !out1_o);
endmodule

// File: tb/preset_down_counter_bench.sv
module preset_down_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a = 1'b0, b = 1'b0, clr = 1'b0;
  logic        pair = 1'b0, wrap = 1'b0, latch = 1'b1;
  logic [19:0] preset = '0;
  logic [7:0]  cmin = 8'd2;
  logic [15:0] plen = 16'd3;
  logic [19:0] pv;
  logic        o1, o2;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  preset_down_counter u_preset_down_counter (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(a), .cnt_b_i(b), .clr_i(clr),
    .pair_sel_i(pair), .wrap_en_i(wrap), .latch_en_i(latch),
    .preset_i(preset), .clr_min_i(cmin), .pulse_len_i(plen),
    .pv_o(pv), .out1_o(o1), .out2_o(o2)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    a = 1'b1; wait_n(4); a = 1'b0; wait_n(4);
  endtask

  task automatic pulse_b_low();
    b = 1'b0; wait_n(4); b = 1'b1; wait_n(4);
  endtask

  task automatic apply_clr(input int w);
    clr = 1'b1; wait_n(w); clr = 1'b0; wait_n(6);
  endtask

  task automatic t_reset_state();
    wait_n(3); rst_n = 1'b1; wait_n(1);
    chk("R1 pv", pv, 0);
    chk("R1 out1", o1, 0);
    chk("R1 out2", o2, 0);
  endtask

  task automatic t_pair_a();
    pair = 1'b0; latch = 1'b1; wrap = 1'b0;
    preset = 20'd10; apply_clr(3);
    chk("R4 load", pv, 10);
    preset = 20'd77; wait_n(3);
    chk("R4 preset change ignored", pv, 10);
    pulse_a(); pulse_a();
    chk("R2 two rising edges", pv, 8);
    b = 1'b1; wait_n(4); pulse_a(); b = 1'b0; wait_n(4);
    chk("R2 gated by B high", pv, 8);
    preset = 20'hFFFFF; apply_clr(3);
    chk("R4 clamp", pv, 999999);
  endtask

  task automatic t_pair_b();
    b = 1'b1; wait_n(2); a = 1'b1; wait_n(6);
    pair = 1'b1; preset = 20'd6; apply_clr(3);
    pulse_b_low();
    chk("R3 falling edge counts", pv, 5);
    a = 1'b0; wait_n(4); pulse_b_low();
    chk("R3 gated by A low", pv, 5);
    a = 1'b1; wait_n(4); pulse_b_low();
    chk("R3 counts again", pv, 4);
    b = 1'b0; wait_n(2); a = 1'b0; wait_n(6); pair = 1'b0; wait_n(2);
  endtask

  task automatic t_clear_block();
    preset = 20'd5; apply_clr(3);
    clr = 1'b1; wait_n(3); pulse_a(); pulse_a();
    chk("R5 blocked while clear high", pv, 5);
    clr = 1'b0; wait_n(6); pulse_a();
    chk("R5 resumes after clear", pv, 4);
  endtask

  task automatic t_min_width();
    cmin = 8'd4; latch = 1'b1; preset = 20'd7; apply_clr(6);
    chk("R6 long clear taken", pv, 7);
    pulse_a();
    preset = 20'd3; apply_clr(2);
    chk("R6 short clear ignored", pv, 6);
    apply_clr(4);
    chk("R6 exact width taken", pv, 3);
    preset = 20'd1; apply_clr(4); pulse_a();
    chk("R7 zero output", o1, 1);
    apply_clr(3);
    chk("R6 short clear keeps output", o2, 1);
    chk("R6 short clear keeps pv", pv, 0);
    cmin = 8'd0; preset = 20'd9; apply_clr(1);
    chk("R6 min 0 acts as 1", pv, 9);
    chk("R4 clear drops outputs", o1, 0);
    cmin = 8'd2;
  endtask

  task automatic t_zero_same_edge();
    int seen_bad;
    latch = 1'b1; wrap = 1'b0; preset = 20'd3; apply_clr(3);
    seen_bad = 0;
    a = 1'b1;
    for (int k = 0; k < 3; k++) begin
      a = 1'b1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if ((pv == 0) != o1 || o1 != o2) seen_bad++;
        if (c == 3) a = 1'b0;
      end
    end
    chk("R7 outputs track zero arrival", seen_bad, 0);
    pulse_a();
    chk("R8 holds at zero", pv, 0);
    chk("R11 latched output", o1, 1);
  endtask

  task automatic t_wrap();
    wrap = 1'b1; latch = 1'b1; preset = 20'd1; apply_clr(3);
    pulse_a(); pulse_a();
    chk("R9 wrap to top", pv, 999999);
    pulse_a();
    chk("R9 keeps counting", pv, 999998);
    chk("R11 latched after wrap", o2, 1);
    latch = 1'b0; plen = 16'd3; apply_clr(3);
    pulse_a(); pulse_a();
    chk("R9 pulse done after wrap", o1, 0);
    wrap = 1'b0;
  endtask

  task automatic t_pulse_len(input int len, input int exp);
    int hi1, hi2;
    latch = 1'b0; plen = 16'(len); preset = 20'd2; apply_clr(3);
    pulse_a();
    hi1 = 0; hi2 = 0;
    a = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (o1) hi1++;
      if (o2) hi2++;
    end
    a = 1'b0; wait_n(4);
    chk("R10 out1 pulse length", hi1, exp);
    chk("R10 out2 pulse length", hi2, exp);
  endtask

  task automatic t_race();
    latch = 1'b1; cmin = 8'd1; preset = 20'd4; apply_clr(3);
    preset = 20'd8;
    clr = 1'b1; a = 1'b1; wait_n(4); clr = 1'b0; wait_n(6);
    a = 1'b0; wait_n(6);
    chk("R12 clear wins over edge", pv, 8);
    cmin = 8'd2;
  endtask

  initial begin
    t_reset_state();
    t_pair_a();
    t_pair_b();
    t_clear_block();
    t_min_width();
    t_zero_same_edge();
    t_wrap();
    t_pulse_len(5, 5);
    t_pulse_len(0, 1);
    t_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule